// File: doc/BRIEF.md
# Character LCD Bus Transaction Engine

This block is the host side of an 8-bit parallel character-display bus. A client hands it one byte at a time through a valid/ready handshake, together with a flag that marks the byte as a command or as display data. The engine then runs the bus sequence on the register-select, read/write and enable lines and on the data port. The data port is split into an output, an output enable and an input, so that a pad ring can build the bidirectional pin.

The engine has two pacing modes, chosen per request by `mode_i`. In polling mode it reads the display's busy flag before each write and repeats that read until the flag clears. If the flag is still set after a bounded number of reads, the engine gives up, flags an error and drops the request. In fixed-delay mode it never reads the bus. Instead it holds off the next request for a time that depends on the command: the slow clear and home commands get a long wait, and every other command and all data writes get a short one.

The setup time before enable rises, the enable high time and the hold time after enable falls are all parameters counted in clock cycles. The two wait lengths and the poll limit are parameters too.

Top module: `lcd_bus_engine`

## Requirements
- R1: A write cycle drives read/write low, enables the data output (`lcd_db_oe_o`=1) with the request byte on `lcd_db_o`, and drives register select to the request's `req_rs_i`: 0 for a command, 1 for data.
- R2: A busy-flag read drives register select 0, read/write 1 and `lcd_db_oe_o`=0, so the data port is released whenever read/write is high.
- R3: Every bus cycle raises enable for exactly PULSE_CYC clocks. Register select, read/write and data are settled SETUP_CYC clocks before enable rises and do not change while enable is high or for HOLD_CYC clocks after it falls.
- R4: In polling mode (`mode_i`=0), every write is preceded by busy reads. The engine samples bit 7 of `lcd_db_i` as enable falls (1 = busy), repeats the read while it is 1, and issues the write after the first read that returns 0.
- R5: If POLL_LIMIT consecutive reads all return busy, no write is issued, `err_o` goes to 1 and the engine returns to idle. `err_o` stays at 1 until the next request is accepted, which clears it.
- R6: In fixed-delay mode (`mode_i`=1), no read cycle occurs. After a command write of 01h, 02h or 03h, ready returns HOLD_CYC+LONG_WAIT_CYC clocks after enable falls.
- R7: In fixed-delay mode, every other command byte and every data write (including data 01h) returns ready HOLD_CYC+SHORT_WAIT_CYC clocks after enable falls.
- R8: `req_ready_o` is 1 only when the engine is idle, and a request is taken on a clock where `req_valid_i` and `req_ready_o` are both 1. After reset: ready 1, enable 0, output enable 0, `err_o` 0.
- R9: In polling mode, ready returns HOLD_CYC clocks after the write's enable falls, with no extra wait.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 1 | Pacing for the request: 0 busy polling, 1 fixed delay |
| req_valid_i | input | 1 | Request valid |
| req_rs_i | input | 1 | Request kind: 0 command, 1 data |
| req_data_i | input | 8 | Request byte |
| req_ready_o | output | 1 | Engine idle and able to take a request |
| lcd_rs_o | output | 1 | Register select to display |
| lcd_rw_o | output | 1 | Read (1) / write (0) to display |
| lcd_e_o | output | 1 | Enable strobe to display |
| lcd_db_o | output | 8 | Data port output value |
| lcd_db_oe_o | output | 1 | Data port output enable |
| lcd_db_i | input | 8 | Data port input value |
| err_o | output | 1 | Busy-poll timeout flag |

## Verification
The hardest situation to reach from the ports is the poll timeout. It needs a display that stays busy through exactly POLL_LIMIT reads, and also one that clears on the last allowed read so the two sides of the limit can be told apart. The bench models the display as a counter of remaining busy reads that drives bit 7 of `lcd_db_i` whenever read/write is high, and it decrements on each enable fall. Presetting that counter to POLL_LIMIT-1 or to POLL_LIMIT places the run on either side of the limit. Gaps from enable fall to ready are measured in the bench to separate the long and short waits.

// File: rtl/lcd_bus_pkg.sv
package lcd_bus_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_PULSE,
    ST_HOLD,
    ST_WAIT
  } lcd_state_e;
endpackage

// File: rtl/lcd_phase_timer.sv
module lcd_phase_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] val_i,
  output logic             done_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (load_i)        cnt_q <= val_i;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign done_o = (cnt_q == '0);
endmodule

// File: rtl/lcd_wait_sel.sv
module lcd_wait_sel #(
  parameter int CNT_W          = 8,
  parameter int SHORT_WAIT_CYC = 10,
  parameter int LONG_WAIT_CYC  = 400
) (
  input  logic             is_data_i,
  input  logic [7:0]       byte_i,
  output logic [CNT_W-1:0] wait_m1_o
);
  logic slow_cmd;

  // clear (01h) and home (02h/03h) are the slow commands
  assign slow_cmd  = !is_data_i && (byte_i[7:2] == 6'd0) && (byte_i[1:0] != 2'd0);
  assign wait_m1_o = slow_cmd ? CNT_W'(LONG_WAIT_CYC - 1) : CNT_W'(SHORT_WAIT_CYC - 1);
endmodule

// File: rtl/lcd_poll_guard.sv
module lcd_poll_guard #(
  parameter int POLL_LIMIT = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic inc_i,
  output logic last_o
);
  localparam int PW = $clog2(POLL_LIMIT + 1);
  logic [PW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (inc_i)  cnt_q <= cnt_q + 1'b1;
  end

  // the read now ending is the last allowed one
  assign last_o = (cnt_q == PW'(POLL_LIMIT - 1));
endmodule

// File: rtl/lcd_bus_engine.sv
module lcd_bus_engine #(
  parameter int SETUP_CYC      = 2,
  parameter int PULSE_CYC      = 60,
  parameter int HOLD_CYC       = 2,
  parameter int SHORT_WAIT_CYC = 5000,
  parameter int LONG_WAIT_CYC  = 205000,
  parameter int POLL_LIMIT     = 1000
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       mode_i,
  input  logic       req_valid_i,
  input  logic       req_rs_i,
  input  logic [7:0] req_data_i,
  output logic       req_ready_o,
  output logic       lcd_rs_o,
  output logic       lcd_rw_o,
  output logic       lcd_e_o,
  output logic [7:0] lcd_db_o,
  output logic       lcd_db_oe_o,
  input  logic [7:0] lcd_db_i,
  output logic       err_o
);
  import lcd_bus_pkg::*;

  localparam int MAX_A = (SETUP_CYC > PULSE_CYC) ? SETUP_CYC : PULSE_CYC;
  localparam int MAX_B = (HOLD_CYC > SHORT_WAIT_CYC) ? HOLD_CYC : SHORT_WAIT_CYC;
  localparam int MAX_C = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int MAX_ALL = (MAX_C > LONG_WAIT_CYC) ? MAX_C : LONG_WAIT_CYC;
  localparam int CNT_W = $clog2(MAX_ALL + 1);

  lcd_state_e st_q, st_d;
  logic             rs_q, rw_q, oe_q, busy_q, err_q, mode_q, req_rs_q;
  logic [7:0]       db_q, byte_q;
  logic             tmr_ld, tmr_done;
  logic [CNT_W-1:0] tmr_val, wait_m1;
  logic             acc, to_write, go_idle, smp, poll_inc, poll_last, err_set;

  lcd_phase_timer #(.CNT_W(CNT_W)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (tmr_ld),
    .val_i  (tmr_val),
    .done_o (tmr_done)
  );

  lcd_wait_sel #(
    .CNT_W          (CNT_W),
    .SHORT_WAIT_CYC (SHORT_WAIT_CYC),
    .LONG_WAIT_CYC  (LONG_WAIT_CYC)
  ) u_wait (
    .is_data_i (req_rs_q),
    .byte_i    (byte_q),
    .wait_m1_o (wait_m1)
  );

  lcd_poll_guard #(.POLL_LIMIT(POLL_LIMIT)) u_guard (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (acc),
    .inc_i  (poll_inc),
    .last_o (poll_last)
  );

  always_comb begin
    st_d     = st_q;
    tmr_ld   = 1'b0;
    tmr_val  = '0;
    acc      = 1'b0;
    to_write = 1'b0;
    go_idle  = 1'b0;
    smp      = 1'b0;
    poll_inc = 1'b0;
    err_set  = 1'b0;
    unique case (st_q)
      ST_IDLE: if (req_valid_i) begin
        acc = 1'b1; st_d = ST_SETUP; tmr_ld = 1'b1; tmr_val = CNT_W'(SETUP_CYC - 1);
      end
      ST_SETUP: if (tmr_done) begin
        st_d = ST_PULSE; tmr_ld = 1'b1; tmr_val = CNT_W'(PULSE_CYC - 1);
      end
      ST_PULSE: if (tmr_done) begin
        smp = rw_q; st_d = ST_HOLD; tmr_ld = 1'b1; tmr_val = CNT_W'(HOLD_CYC - 1);
      end
      ST_HOLD: if (tmr_done) begin
        if (rw_q) begin
          if (busy_q) begin
            poll_inc = 1'b1;
            if (poll_last) begin
              err_set = 1'b1; go_idle = 1'b1; st_d = ST_IDLE;
            end else begin
              st_d = ST_SETUP; tmr_ld = 1'b1; tmr_val = CNT_W'(SETUP_CYC - 1);
            end
          end else begin
            to_write = 1'b1; st_d = ST_SETUP; tmr_ld = 1'b1; tmr_val = CNT_W'(SETUP_CYC - 1);
          end
        end else if (mode_q) begin
          st_d = ST_WAIT; tmr_ld = 1'b1; tmr_val = wait_m1;
        end else begin
          go_idle = 1'b1; st_d = ST_IDLE;
        end
      end
      ST_WAIT: if (tmr_done) begin
        go_idle = 1'b1; st_d = ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= ST_IDLE;
      rs_q     <= 1'b0;
      rw_q     <= 1'b0;
      oe_q     <= 1'b0;
      db_q     <= '0;
      busy_q   <= 1'b0;
      err_q    <= 1'b0;
      mode_q   <= 1'b0;
      req_rs_q <= 1'b0;
      byte_q   <= '0;
    end else begin
      st_q <= st_d;
      if (acc) begin
        mode_q   <= mode_i;
        req_rs_q <= req_rs_i;
        byte_q   <= req_data_i;
        err_q    <= 1'b0;
        if (!mode_i) begin
          rs_q <= 1'b0; rw_q <= 1'b1; oe_q <= 1'b0;
        end else begin
          rs_q <= req_rs_i; rw_q <= 1'b0; oe_q <= 1'b1; db_q <= req_data_i;
        end
      end
      if (to_write) begin
        rs_q <= req_rs_q; rw_q <= 1'b0; oe_q <= 1'b1; db_q <= byte_q;
      end
      if (go_idle) begin
        rw_q <= 1'b0; oe_q <= 1'b0;
      end
      if (smp)     busy_q <= lcd_db_i[7];
      if (err_set) err_q  <= 1'b1;
    end
  end

  assign req_ready_o = (st_q == ST_IDLE);
  assign lcd_e_o     = (st_q == ST_PULSE);
  assign lcd_rs_o    = rs_q;
  assign lcd_rw_o    = rw_q;
  assign lcd_db_o    = db_q;
  assign lcd_db_oe_o = oe_q;
  assign err_o       = err_q;
endmodule

// File: rtl/lcd_bus_engine_chk.sv
module lcd_bus_engine_chk #(
  parameter int SETUP_CYC = 2,
  parameter int PULSE_CYC = 60
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       req_ready_o,
  input logic       lcd_rs_o,
  input logic       lcd_rw_o,
  input logic       lcd_e_o,
  input logic [7:0] lcd_db_o,
  input logic       lcd_db_oe_o,
  input logic       err_o
);
  logic [10:0] cfg, cfg_prev;
  int unsigned e_run, cfg_run;

  assign cfg = {lcd_rs_o, lcd_rw_o, lcd_db_oe_o, lcd_db_oe_o ? lcd_db_o : 8'h00};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      e_run    <= 0;
      cfg_run  <= 0;
      cfg_prev <= '0;
    end else begin
      cfg_prev <= cfg;
      e_run    <= lcd_e_o ? e_run + 1 : 0;
      cfg_run  <= (lcd_e_o || cfg != cfg_prev) ? 0 : cfg_run + 1;
    end
  end

  a_r3_e_width: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(lcd_e_o) |-> e_run == PULSE_CYC);

  // cfg_run lags one sample behind the settled interval
  a_r3_setup: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(lcd_e_o) |-> cfg_run >= SETUP_CYC - 1);

  a_r3_stable_in_e: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lcd_e_o && $past(lcd_e_o)) |-> $stable(cfg));

  a_r2_released_on_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lcd_rw_o |-> !lcd_db_oe_o);

  a_r8_ready_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> !lcd_e_o);

  a_r5_err_at_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(err_o) |-> req_ready_o);
endmodule

bind lcd_bus_engine lcd_bus_engine_chk #(
  .SETUP_CYC (SETUP_CYC),
  .PULSE_CYC (PULSE_CYC)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_ready_o (req_ready_o),
  .lcd_rs_o    (lcd_rs_o),
  .lcd_rw_o    (lcd_rw_o),
  .lcd_e_o     (lcd_e_o),
  .lcd_db_o    (lcd_db_o),
  .lcd_db_oe_o (lcd_db_oe_o),
  .err_o       (err_o)
);

// File: tb/sim_lcd_bus_engine.sv
`timescale 1ns/1ps
module sim_lcd_bus_engine;
  localparam int S  = 2;
  localparam int P  = 3;
  localparam int H  = 2;
  localparam int SW = 10;
  localparam int LW = 400;
  localparam int PL = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic mode = 1'b0, valid = 1'b0, rs = 1'b0;
  logic [7:0] data = 8'h00;
  logic ready, l_rs, l_rw, l_e, l_oe, err;
  logic [7:0] l_db, db_in;

  int busy_left = 0;
  int tests = 0, fails = 0;

  always #4 clk = ~clk;

  lcd_bus_engine #(
    .SETUP_CYC(S), .PULSE_CYC(P), .HOLD_CYC(H),
    .SHORT_WAIT_CYC(SW), .LONG_WAIT_CYC(LW), .POLL_LIMIT(PL)
  ) u0 (
    .clk_i(clk), .rst_ni(rst_n), .mode_i(mode), .req_valid_i(valid),
    .req_rs_i(rs), .req_data_i(data), .req_ready_o(ready),
    .lcd_rs_o(l_rs), .lcd_rw_o(l_rw), .lcd_e_o(l_e), .lcd_db_o(l_db),
    .lcd_db_oe_o(l_oe), .lcd_db_i(db_in), .err_o(err)
  );

  // display model: busy bit on DB7 while read/write is high
  assign db_in = l_rw ? {(busy_left > 0), 7'h11} : 8'h00;

  // bus monitor
  logic [10:0] tr_cfg [16];
  int tr_w [16], tr_su [16];
  int ntr = 0, cyc = 0, t_fall = 0, t_rdy = 0, wcnt = 0, su = 0;
  logic pe = 1'b0, pr = 1'b1;
  logic [10:0] pcfg = '0, cfg;

  always @(negedge clk) begin
    cyc++;
    cfg = {l_rs, l_rw, l_oe, l_oe ? l_db : 8'h00};
    if (l_e && !pe) begin
      if (ntr < 16) begin tr_cfg[ntr] = pcfg; tr_su[ntr] = su; end
      wcnt = 1;
    end else if (l_e) wcnt++;
    if (!l_e && pe) begin
      if (ntr < 16) tr_w[ntr] = wcnt;
      if (tr_cfg[ntr][9] && busy_left > 0) busy_left--;
      ntr++;
      t_fall = cyc;
      su = 1;
    end else if (!l_e) su = (cfg == pcfg) ? su + 1 : 1;
    if (ready && !pr) t_rdy = cyc;
    pe = l_e; pr = ready; pcfg = cfg;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic send(input logic m, input logic r, input logic [7:0] d);
    ntr = 0;
    @(negedge clk);
    mode = m; rs = r; data = d; valid = 1'b1;
    @(negedge clk);
    valid = 1'b0;
    chk(!ready, "R8 ready low after accept", ready, 0);
    while (!ready) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic check_bus();
    for (int i = 0; i < ntr && i < 16; i++) begin
      int exp_su;
      exp_su = (i > 0 && tr_cfg[i][9] && tr_cfg[i-1][9]) ? H + S : S;
      chk(tr_w[i] == P, "R3 enable width", tr_w[i], P);
      chk(tr_su[i] == exp_su, "R3 setup", tr_su[i], exp_su);
    end
  endtask

  task automatic t_reset();
    chk(ready && !l_e && !l_oe && !err, "R8 reset state",
        {ready, l_e, l_oe, err}, 4'b1000);
  endtask

  task automatic t_poll_cmd();
    busy_left = 0;
    send(1'b0, 1'b0, 8'h38);
    chk(ntr == 2, "R4 one read then write", ntr, 2);
    chk(tr_cfg[0] == {3'b010, 8'h00}, "R2 busy read lines", tr_cfg[0], {3'b010, 8'h00});
    chk(tr_cfg[1] == {3'b001, 8'h38}, "R1 command write", tr_cfg[1], {3'b001, 8'h38});
    chk(t_rdy - t_fall == H, "R9 poll ready gap", t_rdy - t_fall, H);
    check_bus();
  endtask

  task automatic t_poll_busy();
    busy_left = PL - 1;
    send(1'b0, 1'b1, 8'h5A);
    chk(ntr == PL + 1, "R4 repeated reads", ntr, PL + 1);
    for (int i = 0; i < PL; i++)
      chk(tr_cfg[i] == {3'b010, 8'h00}, "R4 read before write", tr_cfg[i], {3'b010, 8'h00});
    chk(tr_cfg[PL] == {3'b101, 8'h5A}, "R1 data write", tr_cfg[PL], {3'b101, 8'h5A});
    chk(!err, "R5 no error under limit", err, 0);
    check_bus();
  endtask

  task automatic t_timeout();
    busy_left = PL;
    send(1'b0, 1'b0, 8'h0C);
    chk(ntr == PL, "R5 reads only at limit", ntr, PL);
    chk(tr_cfg[PL-1][9] == 1'b1, "R5 last cycle a read", tr_cfg[PL-1][9], 1);
    chk(err, "R5 error raised", err, 1);
    busy_left = 0;
    send(1'b0, 1'b0, 8'h0E);
    chk(!err, "R5 error cleared", err, 0);
    chk(ntr == 2 && tr_cfg[1] == {3'b001, 8'h0E}, "R5 recovery write", tr_cfg[1], {3'b001, 8'h0E});
  endtask

  task automatic t_fixed(input logic r, input logic [7:0] d, input bit slow);
    int exp_gap;
    busy_left = 5;
    send(1'b1, r, d);
    exp_gap = H + (slow ? LW : SW);
    chk(ntr == 1, "R6 no read in fixed mode", ntr, 1);
    chk(tr_cfg[0] == {r, 2'b01, d}, "R1 fixed write", tr_cfg[0], {r, 2'b01, d});
    if (slow) chk(t_rdy - t_fall == exp_gap, "R6 long wait", t_rdy - t_fall, exp_gap);
    else      chk(t_rdy - t_fall == exp_gap, "R7 short wait", t_rdy - t_fall, exp_gap);
    check_bus();
    busy_left = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_poll_cmd();
    t_poll_busy();
    t_timeout();
    t_fixed(1'b0, 8'h01, 1'b1);
    t_fixed(1'b0, 8'h02, 1'b1);
    t_fixed(1'b0, 8'h03, 1'b1);
    t_fixed(1'b0, 8'h04, 1'b0);
    t_fixed(1'b0, 8'h80, 1'b0);
    t_fixed(1'b1, 8'h01, 1'b0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(8 * 200000);
    tests++; fails++;
    $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule